// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block drives a two-wire debug link as its master. The link has one clock line, which the master always drives, and one shared data line. The data line appears here as three ports: an output value, an output enable and a sampled input. A host asks for one primitive at a time: read the target's address register, write it, read the data register selected by that address, write that data register, or reset the target. The master builds the whole frame bit by bit and reports the result. When the frame ends it pulses `done`, and for reads the byte is on `rd_byte`.

Each frame is a sequence of clock strobes. A strobe is a low phase of the clock line followed by a high phase. The master changes the data line only while the clock is high. The shape of a frame depends on the primitive:

- **Address frames** carry an instruction and one byte.
- **Data reads** add a length field, then wait for the target before the byte.
- **Data writes** add a length field, send the byte, then wait for the target.

The target signals that it is ready by driving the line to 1. If it never does, the wait gives up after a programmable number of strobes and raises an error flag. The width of each strobe phase is set by the `half_cyc` input, in system clock cycles.

Top module: `dbg2w_master`

## Requirements
- R1: After reset, and whenever the master is idle, `line_clk` is 1, `data_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Every frame starts with one strobe with `data_oe` low (START) and ends with one strobe with `data_oe` low (STOP). A frame contains no other strobes than the fields listed in R3 to R8.
- R3: After START, two instruction strobes drive `data_out`, least significant bit first. The instruction value is 2'b10 for an address read, 2'b11 for an address write, 2'b00 for a data read and 2'b01 for a data write. The host selects the primitive with `op_code`: 0 is address read, 1 address write, 2 data read, 3 data write, 4 target reset.
- R4: Data frames follow the instruction with two driven strobes of value 0 (a length of one byte). Address frames have no such field.
- R5: The byte moves least significant bit first, one bit per strobe. On writes, the bits of `wr_byte` are driven with `data_out`. On reads, `data_oe` is low, the line is sampled at the end of each strobe, and after an address read or a successful data read `rd_byte` holds the assembled byte when `done` pulses.
- R6: A data read releases the line after the length field and strobes until it samples a 1. It then reads the 8 data bits.
- R7: A data write drives its 8 bits, then releases the line and strobes until it samples a 1. STOP follows.
- R8: If `wait_limit` wait strobes pass with no 1 sampled (a limit of 0 acts as 1), the master sets `wait_err`, goes straight to STOP and leaves `rd_byte` unchanged. `wait_err` clears when the next operation is accepted.
- R9: Each strobe's low phase lasts exactly `half_cyc` system cycles (0 acts as 1), and its high phase lasts at least that long. `data_out` and `data_oe` do not change while `line_clk` is low.
- R10: The target reset operation holds `line_clk` low for exactly `RST_CYC` cycles with `data_oe` low, then releases it high and pulses `done`.
- R11: A start request is ignored while `busy` is high, and it is ignored when `op_code` is 5, 6 or 7.
- R12: `done` is a single-cycle pulse, raised in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cyc | input | PW | Strobe phase width in system cycles |
| wait_limit | input | WW | Maximum number of wait strobes |
| op_start | input | 1 | Start request pulse |
| op_code | input | 3 | Primitive selector |
| wr_byte | input | 8 | Byte to send on address or data writes |
| rd_byte | output | 8 | Byte received by the last completed read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| wait_err | output | 1 | The last operation timed out in its wait field |
| line_clk | output | 1 | Debug clock line, idles high |
| data_out | output | 1 | Value driven onto the data line |
| data_oe | output | 1 | Data line driver enable |
| data_in | input | 1 | Sampled level of the data line |

## Verification
The hardest situation to reach is a wait field whose ready bit arrives at a chosen strobe, or never arrives. The ready bit must line up with exactly one strobe of a frame that is still running. The bench answers this with a scripted target that feeds `data_in` per strobe, taking each value from the same queue entry that holds the expected line state. Zero, one or several wait strobes, as well as a timeout, are then just different script lengths. For the timeout case, the script runs out on the limit strobe, so the bench can check that STOP comes next and that no data bits follow.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [2:0] {
    OP_AR_RD = 3'd0,
    OP_AR_WR = 3'd1,
    OP_DR_RD = 3'd2,
    OP_DR_WR = 3'd3,
    OP_TRST  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    F_START, F_INS, F_LEN, F_BYTE, F_WAIT, F_STOP
  } fld_e;

  typedef enum logic [1:0] {
    S_IDLE, S_FRAME, S_TRST
  } st_e;

  // Instruction code for each frame primitive; bit 0 goes out first.
  function automatic logic [1:0] ins_code(op_e op);
    case (op)
      OP_AR_RD: ins_code = 2'b10;
      OP_AR_WR: ins_code = 2'b11;
      OP_DR_RD: ins_code = 2'b00;
      default:  ins_code = 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/dbg2w_strobe.sv
module dbg2w_strobe #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] half_cyc,
  input  logic          go,
  output logic          low,
  output logic          sbusy,
  output logic          last
);

  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;

  ph_e           ph_q, ph_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] load;

  assign load = (half_cyc == '0) ? '0 : half_cyc - 1'b1;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      P_IDLE: begin
        if (go) begin
          ph_d  = P_LOW;
          cnt_d = load;
        end
      end
      P_LOW: begin
        if (cnt_q == '0) begin
          ph_d  = P_HIGH;
          cnt_d = load;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) ph_d = P_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= P_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign low   = (ph_q == P_LOW);
  assign sbusy = (ph_q != P_IDLE);
  assign last  = (ph_q == P_HIGH) && (cnt_q == '0);

endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int WW      = 8,
  parameter int RST_CYC = 2100,
  localparam int RSTW   = $clog2(RST_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [2:0]    op_code,
  input  logic [7:0]    wr_byte,
  input  logic [WW-1:0] wait_limit,
  input  logic          data_in,
  input  logic          strb_last,
  input  logic          strb_busy,
  output logic          strb_go,
  output logic          hold_low,
  output logic          data_out,
  output logic          data_oe,
  output logic [7:0]    rd_byte,
  output logic          busy,
  output logic          done,
  output logic          wait_err
);

  st_e           st_q, st_d;
  fld_e          fld_q, fld_d;
  op_e           op_q, op_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    wbuf_q, wbuf_d, sh_q, sh_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [RSTW-1:0] rcnt_q, rcnt_d;
  logic          pend_q, pend_d, dout_q, dout_d, oe_q, oe_d;
  logic          done_q, done_d, err_q, err_d;
  logic          is_data, is_rd;
  logic [1:0]    ins;
  logic [WW:0]   wnext;

  assign is_data = (op_q == OP_DR_RD) || (op_q == OP_DR_WR);
  assign is_rd   = (op_q == OP_DR_RD) || (op_q == OP_AR_RD);
  assign ins     = ins_code(op_q);
  assign wnext   = {1'b0, wcnt_q} + 1'b1;

  always_comb begin
    st_d = st_q;  fld_d = fld_q;  op_d = op_q;  idx_d = idx_q;
    wbuf_d = wbuf_q;  sh_d = sh_q;  wcnt_d = wcnt_q;  rcnt_d = rcnt_q;
    pend_d = pend_q;  dout_d = dout_q;  oe_d = oe_q;  err_d = err_q;
    done_d = 1'b0;
    strb_go = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (op_start && (op_code <= 3'd4)) begin
          op_d   = op_e'(op_code);
          wbuf_d = wr_byte;
          err_d  = 1'b0;
          oe_d   = 1'b0;
          pend_d = 1'b0;
          if (op_code == 3'd4) begin
            st_d   = S_TRST;
            rcnt_d = RSTW'(RST_CYC - 1);
          end else begin
            st_d  = S_FRAME;
            fld_d = F_START;
          end
        end
      end
      S_TRST: begin
        if (rcnt_q == '0) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end else begin
          rcnt_d = rcnt_q - 1'b1;
        end
      end
      default: begin
        if (!pend_q) begin
          if (!strb_busy) begin
            strb_go = 1'b1;
            pend_d  = 1'b1;
          end
        end else if (strb_last) begin
          pend_d = 1'b0;
          case (fld_q)
            F_START: begin
              fld_d = F_INS;  idx_d = '0;  oe_d = 1'b1;  dout_d = ins[0];
            end
            F_INS: begin
              if (idx_q == '0) begin
                idx_d = 3'd1;  dout_d = ins[1];
              end else if (is_data) begin
                fld_d = F_LEN;  idx_d = '0;  dout_d = 1'b0;
              end else begin
                fld_d = F_BYTE;  idx_d = '0;  oe_d = !is_rd;  dout_d = wbuf_q[0];
              end
            end
            F_LEN: begin
              if (idx_q == '0) begin
                idx_d = 3'd1;  dout_d = 1'b0;
              end else if (op_q == OP_DR_RD) begin
                fld_d = F_WAIT;  wcnt_d = '0;  oe_d = 1'b0;
              end else begin
                fld_d = F_BYTE;  idx_d = '0;  dout_d = wbuf_q[0];
              end
            end
            F_BYTE: begin
              if (is_rd) begin
                sh_d = {data_in, sh_q[7:1]};
              end else begin
                wbuf_d = wbuf_q >> 1;
                dout_d = wbuf_q[1];
              end
              if (idx_q == 3'd7) begin
                oe_d   = 1'b0;
                wcnt_d = '0;
                fld_d  = (op_q == OP_DR_WR) ? F_WAIT : F_STOP;
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end
            F_WAIT: begin
              if (data_in) begin
                fld_d = (op_q == OP_DR_RD) ? F_BYTE : F_STOP;
                idx_d = '0;
              end else if (wnext >= {1'b0, wait_limit}) begin
                err_d = 1'b1;
                fld_d = F_STOP;
              end else begin
                wcnt_d = wnext[WW-1:0];
              end
            end
            default: begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  fld_q <= F_START;  op_q <= OP_AR_RD;  idx_q <= '0;
      wbuf_q <= '0;  sh_q <= '0;  wcnt_q <= '0;  rcnt_q <= '0;
      pend_q <= 1'b0;  dout_q <= 1'b0;  oe_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  fld_q <= fld_d;  op_q <= op_d;  idx_q <= idx_d;
      wbuf_q <= wbuf_d;  sh_q <= sh_d;  wcnt_q <= wcnt_d;  rcnt_q <= rcnt_d;
      pend_q <= pend_d;  dout_q <= dout_d;  oe_q <= oe_d;
      done_q <= done_d;  err_q <= err_d;
    end
  end

  assign hold_low = (st_q == S_TRST);
  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign wait_err = err_q;
  assign data_out = dout_q;
  assign data_oe  = oe_q;
  assign rd_byte  = sh_q;

endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int PW      = 8,
  parameter int WW      = 8,
  parameter int RST_CYC = 2100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] half_cyc,
  input  logic [WW-1:0] wait_limit,
  input  logic          op_start,
  input  logic [2:0]    op_code,
  input  logic [7:0]    wr_byte,
  output logic [7:0]    rd_byte,
  output logic          busy,
  output logic          done,
  output logic          wait_err,
  output logic          line_clk,
  output logic          data_out,
  output logic          data_oe,
  input  logic          data_in
);

  logic strb_go, strb_low, strb_busy, strb_last, hold_low;

  dbg2w_strobe #(.PW(PW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_cyc), .go(strb_go),
    .low(strb_low), .sbusy(strb_busy), .last(strb_last)
  );

  dbg2w_seq #(.WW(WW), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .wr_byte(wr_byte), .wait_limit(wait_limit), .data_in(data_in),
    .strb_last(strb_last), .strb_busy(strb_busy), .strb_go(strb_go),
    .hold_low(hold_low), .data_out(data_out), .data_oe(data_oe),
    .rd_byte(rd_byte), .busy(busy), .done(done), .wait_err(wait_err)
  );

  assign line_clk = !(strb_low || hold_low);

endmodule

// File: rtl/dbg2w_chk.sv
module dbg2w_chk (
  input logic clk,
  input logic rst_n,
  input logic op_start,
  input logic busy,
  input logic done,
  input logic wait_err,
  input logic line_clk,
  input logic data_out,
  input logic data_oe
);

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_clk && !data_oe));

  a_r9_stable_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk && $past(!line_clk)) |-> ($stable(data_out) && $stable(data_oe)));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_start));

  a_r8_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_err) |-> busy);

endmodule

bind dbg2w_master dbg2w_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .busy(busy), .done(done),
  .wait_err(wait_err), .line_clk(line_clk), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sim_dbg2w_master.sv
module sim_dbg2w_master;

  localparam int CLK_P   = 10;
  localparam int RST_CYC = 2100;

  typedef struct {
    logic  oe;
    logic  d;
    logic  din;
    string req;
  } strb_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_cyc = 8'd2;
  logic [7:0] wait_limit = 8'd8;
  logic       op_start = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] wr_byte = 8'd0;
  logic [7:0] rd_byte;
  logic       busy, done, wait_err, line_clk, data_out, data_oe;
  logic       data_in = 1'b0;

  strb_t      exp_q[$];
  logic [8:0] res_q[$];
  int         n_chk = 0, n_err = 0, done_cnt = 0, cur_half = 2;
  logic [7:0] exp_rd = 8'h00;
  bit         in_trst = 1'b0, fin = 1'b0, chk_pulse = 1'b0;
  time        t_fall = 0;
  logic       sv_d = 1'b0, sv_oe = 1'b0;

  dbg2w_master #(.PW(8), .WW(8), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_cyc), .wait_limit(wait_limit),
    .op_start(op_start), .op_code(op_code), .wr_byte(wr_byte), .rd_byte(rd_byte),
    .busy(busy), .done(done), .wait_err(wait_err), .line_clk(line_clk),
    .data_out(data_out), .data_oe(data_oe), .data_in(data_in)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(logic oe, logic d, logic din, string req);
    strb_t e;
    e.oe = oe;  e.d = d;  e.din = din;  e.req = req;
    exp_q.push_back(e);
  endtask

  // Scoreboard driver: scripts the target and the expected line trace, then starts the op.
  task automatic run_op(int op, logic [7:0] w, logic [7:0] r, int nz, int lim,
                        int half, bit poke);
    logic [1:0] ins;
    int         eff_lim;
    bit         err;
    int         d0;
    eff_lim = (lim == 0) ? 1 : lim;
    err = 1'b0;
    case (op)
      0: ins = 2'b10;
      1: ins = 2'b11;
      2: ins = 2'b00;
      default: ins = 2'b01;
    endcase
    push(1'b0, 1'b0, 1'b0, "R2 start");
    push(1'b1, ins[0], 1'b0, "R3 ins bit0");
    push(1'b1, ins[1], 1'b0, "R3 ins bit1");
    if (op >= 2) begin
      push(1'b1, 1'b0, 1'b0, "R4 length");
      push(1'b1, 1'b0, 1'b0, "R4 length");
    end
    if (op == 0) begin
      for (int i = 0; i < 8; i++) push(1'b0, 1'b0, r[i], "R5 read bit");
      exp_rd = r;
    end
    if (op == 1 || op == 3)
      for (int i = 0; i < 8; i++) push(1'b1, w[i], 1'b0, "R5 write bit");
    if (op >= 2) begin
      for (int k = 0; k < nz && k < eff_lim; k++)
        push(1'b0, 1'b0, 1'b0, (op == 2) ? "R6 wait" : "R7 wait");
      if (nz < eff_lim) begin
        push(1'b0, 1'b0, 1'b1, (op == 2) ? "R6 ready" : "R7 ready");
        if (op == 2) begin
          for (int i = 0; i < 8; i++) push(1'b0, 1'b0, r[i], "R6 read bit");
          exp_rd = r;
        end
      end else begin
        err = 1'b1;
      end
    end
    push(1'b0, 1'b0, 1'b0, "R2 stop");
    res_q.push_back({err, exp_rd});

    @(negedge clk);
    half_cyc = 8'(half);
    cur_half = (half == 0) ? 1 : half;
    wait_limit = 8'(lim);
    op_start = 1'b1;  op_code = 3'(op);  wr_byte = w;
    @(negedge clk);
    op_start = 1'b0;
    d0 = done_cnt;
    if (poke) begin
      repeat (6) @(negedge clk);
      op_start = 1'b1;  op_code = 3'd1;  wr_byte = ~w;   // R11: start while busy
      @(negedge clk);
      op_start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare each strobe against the script and feed the target reply.
  always @(negedge line_clk) begin
    t_fall = $time;
    sv_d = data_out;
    sv_oe = data_oe;
    if (!in_trst) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe", 1, 0);
        data_in <= 1'b0;
      end else begin
        strb_t e;
        e = exp_q.pop_front();
        chk(data_oe == e.oe, e.req, int'(data_oe), int'(e.oe));
        if (e.oe) chk(data_out == e.d, e.req, int'(data_out), int'(e.d));
        data_in <= e.din;
      end
    end
  end

  always @(posedge line_clk) begin
    if (in_trst) begin
      chk(($time - t_fall) == RST_CYC * CLK_P, "R10 reset low time",
          int'($time - t_fall), RST_CYC * CLK_P);
      chk(!data_oe, "R10 no drive", int'(data_oe), 0);
    end else if (rst_n) begin
      chk(($time - t_fall) == cur_half * CLK_P, "R9 low phase",
          int'($time - t_fall), cur_half * CLK_P);
      chk(data_out == sv_d && data_oe == sv_oe, "R9 data held while low",
          int'({data_oe, data_out}), int'({sv_oe, sv_d}));
    end
  end

  always @(negedge clk) begin
    if (chk_pulse) begin
      chk(!done, "R12 done width", int'(done), 0);
      chk_pulse = 1'b0;
    end
    if (rst_n && done) begin
      done_cnt++;
      chk_pulse = 1'b1;
      chk(!busy, "R12 idle at done", int'(busy), 0);
      if (!in_trst) begin
        logic [8:0] r;
        chk(exp_q.size() == 0, "R2 strobe count", exp_q.size(), 0);
        if (res_q.size() != 0) begin
          r = res_q.pop_front();
          chk(rd_byte == r[7:0], "R5 read byte", int'(rd_byte), int'(r[7:0]));
          chk(wait_err == r[8], "R8 wait error", int'(wait_err), int'(r[8]));
        end
      end
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk(line_clk == 1'b1, "R1 idle clock", int'(line_clk), 1);
    chk(data_oe == 1'b0, "R1 idle oe", int'(data_oe), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle status", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(1, 8'hA5, 8'h00, 0, 8, 2, 1'b0);   // R3 R5 address write
    run_op(0, 8'h00, 8'h3C, 0, 8, 1, 1'b0);   // R3 R5 address read
    run_op(3, 8'h5A, 8'h00, 3, 8, 3, 1'b0);   // R7 data write, three waits
    run_op(2, 8'h00, 8'hC9, 0, 4, 2, 1'b0);   // R6 data read, immediate ready
    run_op(2, 8'h00, 8'h81, 2, 4, 0, 1'b0);   // R6 R9 half 0 acts as 1
    run_op(2, 8'h00, 8'hFF, 10, 4, 2, 1'b0);  // R8 read timeout, byte kept
    run_op(3, 8'h33, 8'h00, 5, 0, 1, 1'b0);   // R8 write timeout, limit 0 as 1
    run_op(2, 8'h00, 8'h6E, 1, 3, 1, 1'b0);   // R8 error cleared by next op
    run_op(1, 8'h0F, 8'h00, 0, 8, 2, 1'b1);   // R11 start while busy ignored

    // R11: undefined op code
    d0 = done_cnt;
    @(negedge clk);
    op_start = 1'b1;  op_code = 3'd6;
    @(negedge clk);
    op_start = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && line_clk == 1'b1, "R11 undefined op ignored",
        int'({busy, line_clk}), 1);
    chk(done_cnt == d0, "R11 no done for undefined op", done_cnt, d0);

    // R10: target reset
    in_trst = 1'b1;
    d0 = done_cnt;
    @(negedge clk);
    op_start = 1'b1;  op_code = 3'd4;
    @(negedge clk);
    op_start = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    in_trst = 1'b0;
    chk(line_clk == 1'b1 && busy == 1'b0, "R10 released high",
        int'({line_clk, busy}), 2);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule